// File: doc/BRIEF.md
# Clock Gating Cell with Overrides and Controlled-Signal Delay

This block turns a free-running clock into a gated clock for a power-managed region. A functional enable asks for clock pulses. Two independent override inputs can force the clock on. An active-high synchronous reset also forces the clock on, so that flops in the gated region that reset synchronously still see the edges they need. The effective enable is captured by a register clocked on the falling edge of the input clock, and that register's output is ANDed with the clock. The enable therefore only changes while the clock is low, and every gated high phase is a full high phase of the input clock.

Downstream logic in the gated region often needs a copy of the enable, or of other control bits, that lines up with the gated edges. The block provides a controlled-signal path of configurable width for this purpose. By default the path delays these bits by one input-clock cycle, using a register on the ungated clock. A parameter can make the path combinational instead. A second parameter removes gating entirely: the output clock is then the input clock and the override inputs have no effect. No data stream flows through the block, so every pin is a plain control or clock pin.

Top module: `clk_gate_cell`

## Requirements
- R1: The effective enable is the OR of `func_en`, `ovr_en`, `ovr_aux` and `rst`, sampled at each falling edge of `clk`. `gclk` is high during the next high phase of `clk` exactly when that sampled value is 1.
- R2: While `ovr_en` is 1, `gclk` produces one rising edge per `clk` cycle, whatever the value of `func_en`.
- R3: While `ovr_aux` is 1, `gclk` produces one rising edge per `clk` cycle, independently of `ovr_en` and `func_en`.
- R4: While `rst` is 1, `gclk` produces one rising edge per `clk` cycle.
- R5: With gating present and `func_en`, `ovr_en`, `ovr_aux` and `rst` all 0, `gclk` stays at 0 and has no edges.
- R6: `gclk` is never 1 while `clk` is 0, so a gated high phase is never truncated and never glitches.
- R7: With `DELAY_CTRL`=1, `ctrl_out` equals the value `ctrl_in` had at the previous rising edge of `clk`. A rising edge with `rst`=1 clears `ctrl_out` to 0.
- R8: With `DELAY_CTRL`=0, `ctrl_out` equals `ctrl_in` combinationally.
- R9: With `GATE_PRESENT`=0, `gclk` equals `clk`, and `func_en`, `ovr_en` and `ovr_aux` have no effect on it.
- R10: Consider a counter on `gclk` that adds bit 0 of `ctrl_out`, where `ctrl_in[0]` = `func_en` and both overrides are 0. A burst of k cycles of `func_en`=1, bounded on both sides by cycles with `func_en`=0, advances the counter by exactly k-1. The counter holds while the clock is gated off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous active-high reset; forces the clock on |
| func_en | input | 1 | Functional clock request |
| ovr_en | input | 1 | Main override; forces the clock on |
| ovr_aux | input | 1 | Additional independent override |
| ctrl_in | input | CTRL_W | Control bits to align with the gated domain |
| gclk | output | 1 | Gated clock |
| ctrl_out | output | CTRL_W | Control bits, delayed one cycle or passed through |

## Verification
The assertions assume that the enable and override inputs are stable around each falling edge of `clk`. They also assume that `ctrl_in` and `rst` are stable around each rising edge. Under these conditions the value seen at a sampling edge is the value that was registered. To keep within these conditions, the bench changes every input exactly 1 ns after a rising edge, which falls in the middle of the high phase. It mixes seeded random override and enable combinations and random burst lengths with directed sweeps of every enable combination, and it runs reset with the enable request held low.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // Merge every source that may ask for the clock.
  function automatic logic cg_merge(input logic func_en, input logic ovr_en,
                                    input logic ovr_aux, input logic rst);
    return func_en | ovr_en | ovr_aux | rst;
  endfunction
endpackage

// File: rtl/cg_en_reg.sv
module cg_en_reg (
  input  logic clk,
  input  logic en_d,
  output logic en_q
);
  // Captured on the falling edge: the value only moves while clk is low.
  always_ff @(negedge clk) begin
    en_q <= en_d;
  end
endmodule

// File: rtl/cg_ctrl_path.sv
module cg_ctrl_path #(
  parameter int W     = 4,
  parameter bit DELAY = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DELAY) begin : g_dly
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_thru
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter bit GATE_PRESENT = 1'b1,
  parameter bit DELAY_CTRL   = 1'b1,
  parameter int CTRL_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic              ovr_en,
  input  logic              ovr_aux,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic              gclk,
  output logic [CTRL_W-1:0] ctrl_out
);
  import cg_pkg::*;

  generate
    if (GATE_PRESENT) begin : g_gate
      logic en_eff;
      logic en_q;
      assign en_eff = cg_merge(func_en, ovr_en, ovr_aux, rst);
      cg_en_reg u_en (.clk(clk), .en_d(en_eff), .en_q(en_q));
      assign gclk = clk & en_q;
    end else begin : g_nogate
      logic unused_req;
      assign unused_req = func_en | ovr_en | ovr_aux;
      assign gclk = clk;
    end
  endgenerate

  cg_ctrl_path #(.W(CTRL_W), .DELAY(DELAY_CTRL)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .din (ctrl_in),
    .dout(ctrl_out)
  );
endmodule

// File: rtl/clk_gate_cell_chk.sv
module clk_gate_cell_chk #(
  parameter bit GATE_PRESENT = 1'b1,
  parameter bit DELAY_CTRL   = 1'b1,
  parameter int CTRL_W       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              func_en,
  input logic              ovr_en,
  input logic              ovr_aux,
  input logic [CTRL_W-1:0] ctrl_in,
  input logic              gclk,
  input logic [CTRL_W-1:0] ctrl_out
);
  logic [1:0] n_fall = '0;
  logic [1:0] n_rise = '0;
  always_ff @(negedge clk) if (n_fall != 2'd3) n_fall <= n_fall + 2'd1;
  always_ff @(posedge clk) if (n_rise != 2'd3) n_rise <= n_rise + 2'd1;

  // R6
  gclk_low_phase_chk: assert property (@(posedge clk) disable iff (n_rise == 2'd0) !gclk);

  generate
    if (GATE_PRESENT) begin : g_gate_chk
      // R1
      eff_enable_chk: assert property (@(negedge clk) disable iff (n_fall < 2'd2)
        gclk == $past(func_en | ovr_en | ovr_aux | rst));
      // R2
      ovr_main_chk: assert property (@(negedge clk) disable iff (n_fall < 2'd2)
        $past(ovr_en) |-> gclk);
      // R3
      ovr_aux_chk: assert property (@(negedge clk) disable iff (n_fall < 2'd2)
        $past(ovr_aux) |-> gclk);
      // R4
      rst_force_chk: assert property (@(negedge clk) disable iff (n_fall < 2'd2)
        $past(rst) |-> gclk);
      // R5
      gated_off_chk: assert property (@(negedge clk) disable iff (n_fall < 2'd2)
        !$past(func_en | ovr_en | ovr_aux | rst) |-> !gclk);
    end else begin : g_nogate_chk
      // R9
      ungated_high_chk: assert property (@(negedge clk) disable iff (n_fall == 2'd0) gclk);
    end
    if (DELAY_CTRL) begin : g_dly_chk
      // R7
      ctrl_delay_chk: assert property (@(posedge clk) disable iff (n_rise < 2'd2)
        !$past(rst) |-> ctrl_out == $past(ctrl_in));
      // R7
      ctrl_clear_chk: assert property (@(posedge clk) disable iff (n_rise < 2'd2)
        $past(rst) |-> ctrl_out == '0);
    end else begin : g_thru_chk
      // R8
      always @(negedge clk) begin
        ctrl_thru_chk: assert (ctrl_out == ctrl_in);
      end
    end
  endgenerate
endmodule

bind clk_gate_cell clk_gate_cell_chk #(
  .GATE_PRESENT(GATE_PRESENT), .DELAY_CTRL(DELAY_CTRL), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/clk_gate_cell_tb.sv
`timescale 1ns/1ps
module clk_gate_cell_tb;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic func_en = 1'b0, ovr_en = 1'b0, ovr_aux = 1'b0;
  logic [CW-1:0] ctrl_in = '0;
  logic gclk, gclk_abs, gclk_nd;
  logic [CW-1:0] ctrl_out, ctrl_out_abs, ctrl_out_nd;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  clk_gate_cell #(.GATE_PRESENT(1'b1), .DELAY_CTRL(1'b1), .CTRL_W(CW)) u_dut (
    .clk(clk), .rst(rst), .func_en(func_en), .ovr_en(ovr_en), .ovr_aux(ovr_aux),
    .ctrl_in(ctrl_in), .gclk(gclk), .ctrl_out(ctrl_out));
  clk_gate_cell #(.GATE_PRESENT(1'b0), .DELAY_CTRL(1'b1), .CTRL_W(CW)) u_abs (
    .clk(clk), .rst(rst), .func_en(func_en), .ovr_en(ovr_en), .ovr_aux(ovr_aux),
    .ctrl_in(ctrl_in), .gclk(gclk_abs), .ctrl_out(ctrl_out_abs));
  clk_gate_cell #(.GATE_PRESENT(1'b1), .DELAY_CTRL(1'b0), .CTRL_W(CW)) u_nd (
    .clk(clk), .rst(rst), .func_en(func_en), .ovr_en(ovr_en), .ovr_aux(ovr_aux),
    .ctrl_in(ctrl_in), .gclk(gclk_nd), .ctrl_out(ctrl_out_nd));

  // Gated-domain load and edge counters
  logic [7:0] load_cnt;
  always_ff @(posedge gclk) begin
    if (rst) load_cnt <= '0;
    else     load_cnt <= load_cnt + {7'd0, ctrl_out[0]};
  end
  int e_dut = 0, e_abs = 0;
  always @(posedge gclk)     e_dut++;
  always @(posedge gclk_abs) e_abs++;

  function automatic int exp_edges(input logic f, input logic o, input logic a,
                                   input logic r, input int n);
    return (f | o | a | r) ? n : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Settle one cycle, then count edges over n cycles; also check low phases (R6).
  task automatic measure(input int n, output int d_dut, output int d_abs);
    int s0, s1;
    step();
    s0 = e_dut; s1 = e_abs;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
      chk(gclk == 1'b0 && gclk_nd == 1'b0, "R6", int'(gclk), 0);
      @(posedge clk); #1;
    end
    d_dut = e_dut - s0; d_abs = e_abs - s1;
  endtask

  task automatic combo(input logic f, input logic o, input logic a, input int n);
    int dd, da;
    func_en = f; ovr_en = o; ovr_aux = a;
    measure(n, dd, da);
    if (o)            chk(dd == n, "R2", dd, n);
    else if (a)       chk(dd == n, "R3", dd, n);
    else if (f)       chk(dd == n, "R1", dd, n);
    else              chk(dd == 0, "R5", dd, 0);
    chk(dd == exp_edges(f, o, a, 1'b0, n), "R1", dd, exp_edges(f, o, a, 1'b0, n));
    chk(da == n, "R9", da, n);
  endtask

  initial begin
    int dd, da, seed, k;
    logic [CW-1:0] prev;
    logic [7:0] c0;
    seed = $urandom(32'h5EED_C10C);
    // Reset phase with all requests low
    rst = 1'b1;
    measure(3, dd, da);
    chk(dd == 3, "R4", dd, 3);
    chk(load_cnt == 8'd0, "R10 reset", int'(load_cnt), 0);
    chk(ctrl_out == '0, "R7 reset", int'(ctrl_out), 0);
    rst = 1'b0;
    // Idle: gated off
    measure(5, dd, da);
    chk(dd == 0, "R5", dd, 0);
    chk(da == 5, "R9", da, 5);
    // Directed sweep of every request combination
    for (int c = 0; c < 8; c++) combo(c[0], c[1], c[2], 4);
    // Random combinations
    for (int i = 0; i < 20; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      combo(r[0], r[1], r[2], 1 + int'($urandom % 5));
    end
    // Controlled-signal path
    func_en = 0; ovr_en = 0; ovr_aux = 0;
    step();
    for (int i = 0; i < 30; i++) begin
      prev = 4'($urandom);
      ctrl_in = prev;
      #0.5;
      chk(ctrl_out_nd == prev, "R8", int'(ctrl_out_nd), int'(prev));
      step();
      chk(ctrl_out == prev, "R7", int'(ctrl_out), int'(prev));
    end
    // Synchronous clear of the delay path
    ctrl_in = 4'hF; step();
    rst = 1'b1; step();
    chk(ctrl_out == '0, "R7 clear", int'(ctrl_out), 0);
    rst = 1'b0; ctrl_in = '0;
    step(); step(); step();
    // Bursts driving the gated-domain counter
    for (int b = 0; b < 12; b++) begin
      k = (b < 2) ? b + 1 : 1 + int'($urandom % 6);
      c0 = load_cnt;
      func_en = 1'b1; ctrl_in = 4'b0001;
      repeat (k) step();
      func_en = 1'b0; ctrl_in = '0;
      step(); step();
      chk(load_cnt == 8'(c0 + 8'(k - 1)), "R10", int'(load_cnt), int'(c0) + k - 1);
      c0 = load_cnt;
      step(); step();
      chk(load_cnt == c0, "R10 hold", int'(load_cnt), int'(c0));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule